// File: doc/BRIEF.md
# E1 Frame and CRC4 Multiframe Synchronizer

This block takes a recovered 2.048 Mbit/s E1 bit stream, one bit per clock, and finds the frame boundary. Each frame holds 256 bits, organised as 32 timeslots of 8 bits. While hunting, the block compares every 7-bit window of the stream with the alignment word. A candidate boundary must then be confirmed over three frames before the block declares alignment. Once aligned, it reports the timeslot and bit position of every incoming bit. It also gives a one-clock pulse at the start of each frame. It watches the alignment word in every alignment frame and drops back to hunting after repeated errors.

When CRC4 operation is enabled and frame alignment is held, the block goes on to find the 16-frame CRC4 multiframe. It looks for the 6-bit multiframe alignment word carried in bit 1 of timeslot 0 of the non-alignment frames. The word must be seen twice, two milliseconds apart, inside a bounded window, before multiframe lock is declared. A frame counter measures how long the multiframe search has lasted and raises a give-up flag at a configurable limit. Host logic can use this flag to abandon CRC4 operation.

Top module: `e1_align_sync`

## Requirements
- R1: After reset, `in_sync`, `sync_lost`, `crc_lock`, `crc_giveup`, `frame_pulse` and `mf_pulse` are 0 and `crc_search_cnt` is 0.
- R2: Frame alignment is declared only after three checks pass. The alignment word must appear in timeslot 0 of frame N, with bits 2..8 = 0011011 and bit 1 first on the line. Frame N+1 must carry a 1 in bit 2 of timeslot 0. The alignment word must appear again in frame N+2. `in_sync` rises during frame N+2, on the clock after its bit 8 of timeslot 0.
- R3: If the non-alignment check in frame N+1 fails (bit 2 = 0), the block returns to hunting and does not declare alignment in frame N+2. A later valid three-frame sequence still gives alignment.
- R4: While aligned, `frame_pulse` is high for exactly one clock per frame, when bit 1 of timeslot 0 is on `rx_bit`. `timeslot` gives the timeslot number (0..31) of the current bit, and `bit_pos` gives its bit number minus one (0 = bit 1).
- R5: While aligned, alignment is lost only after LOSS_LIMIT (default 3) consecutive alignment frames carry a wrong alignment word. A correct word resets the error run. When alignment is lost, `sync_lost` goes to 1. It stays at 1 until alignment is declared again.
- R6: A one-clock `resync` pulse drops `in_sync` on the next clock and restarts the hunt.
- R7: With `crc_en` = 1 and frame alignment held, `crc_lock` rises after the multiframe alignment word 001011 has been found twice at the same multiframe phase. The word is read from bit 1 of the non-alignment frames, from the earliest of the six to the latest. The second find must come 16 frames after the first, or a multiple of 16 frames later, and less than MF_WINDOW frames (default 64, 8 ms) after the first.
- R8: While `crc_lock` is 1, `mf_pulse` is high together with `frame_pulse` at the start of frame 0 of each multiframe. Frame 0 is the alignment frame that follows the frame carrying the last bit of the multiframe alignment word by 5 frames. `mf_pulse` is low at the start of every other frame.
- R9: If no second find arrives within MF_WINDOW frames of the first, the window closes. A find that lands exactly at window close becomes a new first find, and a new window starts from it.
- R10: `crc_search_cnt` advances by one per frame while frame alignment is held, `crc_en` = 1 and `crc_lock` = 0. It returns to 0 once `crc_lock` is set.
- R11: While `crc_en` = 0, `crc_search_cnt` is held at 0 and `crc_lock` stays at 0.
- R12: `crc_giveup` is 1 exactly when `crc_search_cnt` is at or above GIVEUP_FRAMES (default 3200, 400 ms).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock, one line bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Serial receive data |
| crc_en | input | 1 | Enables the CRC4 multiframe search |
| resync | input | 1 | Forces a new frame alignment hunt |
| frame_pulse | output | 1 | One-clock pulse on bit 1 of timeslot 0 while aligned |
| mf_pulse | output | 1 | One-clock pulse at start of multiframe frame 0 while locked |
| timeslot | output | 5 | Timeslot number of the current bit |
| bit_pos | output | 3 | Bit number within the timeslot, 0 = bit 1 |
| in_sync | output | 1 | Frame alignment held |
| sync_lost | output | 1 | Alignment was lost by errors and not yet regained |
| crc_lock | output | 1 | CRC4 multiframe alignment held |
| crc_search_cnt | output | 12 | Frames spent searching for multiframe alignment |
| crc_giveup | output | 1 | Search time has reached the give-up limit |

## Verification
Two events can fall in the same cycle. The timeslot-0 check that completes the second multiframe word is also a frame tick on which the search counter would otherwise advance. The multiframe pulse also shares its cycle with the frame pulse. The bench builds a stream whose CRC4 lock falls in a known frame. It samples the counter at the end of the frame before lock, where it expects 40. It samples again at the end of the lock frame, where it expects 0 and not 41. It also counts both pulses bit by bit and expects the multiframe pulse to appear only in the cycle where the frame pulse sits, on bit 1 of frame 0.

// File: rtl/e1s_pkg.sv
package e1s_pkg;

   // Frame alignment tracker states
   typedef enum logic [1:0] {
      FA_HUNT      = 2'd0,
      FA_CONF_NFAS = 2'd1,
      FA_CONF_FAS  = 2'd2,
      FA_LOCKED    = 2'd3
   } fa_state_t;

   // Multiframe search states
   typedef enum logic [1:0] {
      MF_SEEK   = 2'd0,
      MF_SECOND = 2'd1,
      MF_LOCKED = 2'd2
   } mf_state_t;

   // Bits 2..8 of timeslot 0 in an alignment frame, oldest bit as MSB
   localparam logic [6:0] FAS_PATTERN  = 7'b0011011;
   // Bit 1 of the six non-alignment frames that carry the multiframe word
   localparam logic [5:0] MFAS_PATTERN = 6'b001011;
   localparam int         MF_FRAMES    = 16;
   localparam int         MF_IDX_W     = $clog2(MF_FRAMES);
   // Frame index within the multiframe that carries the last word bit
   localparam int         MFAS_LAST_FRAME = 11;

endpackage

// File: rtl/e1s_frame_align.sv
module e1s_frame_align
   import e1s_pkg::*;
#(
   parameter  int TS_COUNT   = 32,
   parameter  int TS_WIDTH   = 8,
   parameter  int LOSS_LIMIT = 3,
   localparam int FRAME_BITS = TS_COUNT * TS_WIDTH,
   localparam int POS_W      = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_bit,
   input  logic             resync,
   output logic [POS_W-1:0] pos,
   output logic             in_sync,
   output logic             sync_lost,
   output logic             tick,
   output logic             fas_frame,
   output logic             frame_pulse
);

   localparam int ERR_W = $clog2(LOSS_LIMIT + 1);

   if (TS_WIDTH != 8) begin : g_bad_width
      $error("e1s_frame_align: timeslot 0 words need TS_WIDTH of 8");
   end
   if (LOSS_LIMIT < 1) begin : g_bad_limit
      $error("e1s_frame_align: LOSS_LIMIT must be at least 1");
   end

   logic [5:0]       hist;
   logic [6:0]       win;
   logic [6:0]       eq;
   logic             fas_hit;
   logic             last_ts0;
   fa_state_t        state, state_nx;
   logic             expect_fas;
   logic [ERR_W-1:0] err_run;
   logic [POS_W-1:0] pos_q;
   logic             lost_q;

   assign win = {hist, rx_bit};

   for (genvar i = 0; i < 7; i++) begin : g_cmp
      assign eq[i] = (win[i] == FAS_PATTERN[i]);
   end

   assign fas_hit  = &eq;
   assign last_ts0 = (pos_q == POS_W'(TS_WIDTH - 1));

   always_comb begin
      state_nx = state;
      unique case (state)
         FA_HUNT:      if (fas_hit) state_nx = FA_CONF_NFAS;
         FA_CONF_NFAS: if (last_ts0) state_nx = win[6] ? FA_CONF_FAS : FA_HUNT;
         FA_CONF_FAS:  if (last_ts0) state_nx = fas_hit ? FA_LOCKED : FA_HUNT;
         FA_LOCKED:    if (last_ts0 && expect_fas && !fas_hit &&
                           err_run == ERR_W'(LOSS_LIMIT - 1))
                          state_nx = FA_HUNT;
         default:      state_nx = FA_HUNT;
      endcase
      if (resync) state_nx = FA_HUNT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist       <= '1;
         state      <= FA_HUNT;
         pos_q      <= '0;
         expect_fas <= 1'b0;
         err_run    <= '0;
         lost_q     <= 1'b0;
      end else begin
         hist  <= {hist[4:0], rx_bit};
         state <= state_nx;
         if (state == FA_HUNT && fas_hit)
            pos_q <= POS_W'(TS_WIDTH);
         else if (pos_q == POS_W'(FRAME_BITS - 1))
            pos_q <= '0;
         else
            pos_q <= pos_q + POS_W'(1);

         if (state == FA_CONF_FAS && state_nx == FA_LOCKED) begin
            expect_fas <= 1'b0;
            err_run    <= '0;
            lost_q     <= 1'b0;
         end else if (state == FA_LOCKED && last_ts0) begin
            expect_fas <= !expect_fas;
            if (expect_fas) begin
               if (fas_hit) begin
                  err_run <= '0;
               end else if (err_run == ERR_W'(LOSS_LIMIT - 1)) begin
                  err_run <= '0;
                  lost_q  <= 1'b1;
               end else begin
                  err_run <= err_run + ERR_W'(1);
               end
            end
         end
      end
   end

   assign pos         = pos_q;
   assign in_sync     = (state == FA_LOCKED);
   assign sync_lost   = lost_q;
   assign tick        = in_sync && last_ts0;
   assign fas_frame   = expect_fas;
   assign frame_pulse = in_sync && (pos_q == '0);

   // R2: alignment is only ever entered from the second-FAS confirmation step
   assert_sync_after_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> $past(state) == FA_CONF_FAS);

   // R4: frame pulse lasts one clock
   assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_pulse |=> !frame_pulse);

   // R5: the loss flag rises only together with leaving alignment
   assert_loss_drops_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_lost) |-> !in_sync && $past(in_sync));

   // R6: a resync request always ends alignment
   assert_resync_hunt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      resync |=> !in_sync);

endmodule

// File: rtl/e1s_mf_align.sv
module e1s_mf_align
   import e1s_pkg::*;
#(
   parameter int POS_W     = 8,
   parameter int MF_WINDOW = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_bit,
   input  logic             crc_en,
   input  logic             in_sync,
   input  logic             tick,
   input  logic             fas_frame,
   input  logic             frame_pulse,
   input  logic [POS_W-1:0] pos,
   output logic             mf_lock,
   output logic             mf_pulse
);

   localparam int WIN_W = $clog2(MF_WINDOW);

   if (MF_WINDOW <= MF_FRAMES) begin : g_bad_window
      $error("e1s_mf_align: MF_WINDOW must exceed one multiframe");
   end

   mf_state_t           state;
   logic                si_cur;
   logic [5:0]          word_sh;
   logic [5:0]          word_nx;
   logic                word_ok;
   logic [WIN_W-1:0]    wcnt;
   logic [MF_IDX_W-1:0] mf_frame;
   logic                active;

   assign active  = in_sync && crc_en;
   assign word_nx = {word_sh[4:0], si_cur};
   assign word_ok = !fas_frame && (word_nx == MFAS_PATTERN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= MF_SEEK;
         si_cur   <= 1'b1;
         word_sh  <= '1;
         wcnt     <= '0;
         mf_frame <= '0;
      end else begin
         if (pos == '0) si_cur <= rx_bit;
         if (!active) begin
            state    <= MF_SEEK;
            word_sh  <= '1;
            wcnt     <= '0;
            mf_frame <= '0;
         end else if (tick) begin
            if (!fas_frame) word_sh <= word_nx;
            mf_frame <= mf_frame + MF_IDX_W'(1);
            unique case (state)
               MF_SEEK: begin
                  if (word_ok) begin
                     state    <= MF_SECOND;
                     wcnt     <= '0;
                     mf_frame <= MF_IDX_W'(MFAS_LAST_FRAME + 1);
                  end
               end
               MF_SECOND: begin
                  wcnt <= wcnt + WIN_W'(1);
                  if (wcnt == WIN_W'(MF_WINDOW - 1)) begin
                     if (word_ok && mf_frame == MF_IDX_W'(MFAS_LAST_FRAME)) begin
                        wcnt <= '0;
                     end else begin
                        state <= MF_SEEK;
                     end
                  end else if (word_ok && mf_frame == MF_IDX_W'(MFAS_LAST_FRAME)) begin
                     state <= MF_LOCKED;
                  end
               end
               MF_LOCKED: state <= MF_LOCKED;
               default:   state <= MF_SEEK;
            endcase
         end
      end
   end

   assign mf_lock  = (state == MF_LOCKED) && active;
   assign mf_pulse = mf_lock && (pos == '0) && (mf_frame == '0);

   // R7: multiframe lock can only rise on a timeslot-0 check
   assert_lock_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mf_lock) |-> $past(tick));

   // R8: the multiframe pulse always coincides with a frame pulse
   assert_mf_with_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mf_pulse |-> frame_pulse);

endmodule

// File: rtl/e1s_search_timer.sv
module e1s_search_timer #(
   parameter int CNT_W         = 12,
   parameter int GIVEUP_FRAMES = 3200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             crc_en,
   input  logic             in_sync,
   input  logic             tick,
   input  logic             mf_lock,
   output logic [CNT_W-1:0] count,
   output logic             giveup
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (GIVEUP_FRAMES >= (1 << CNT_W)) begin : g_bad_limit
      $error("e1s_search_timer: GIVEUP_FRAMES does not fit in CNT_W bits");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!crc_en || mf_lock) begin
         cnt_q <= '0;
      end else if (tick && in_sync && cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   if (GIVEUP_FRAMES == 0) begin : g_no_giveup
      assign giveup = 1'b0;
   end else begin : g_giveup
      assign giveup = (cnt_q >= CNT_W'(GIVEUP_FRAMES));
   end

   assign count = cnt_q;

   // R10: lock clears the search count
   assert_clear_on_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mf_lock |=> count == '0);

   // R11: disabled search keeps the count at zero
   assert_clear_on_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !crc_en |=> count == '0);

   // R12: the give-up flag rises as the count steps onto the limit
   assert_giveup_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(giveup) |-> $past(count) == CNT_W'(GIVEUP_FRAMES - 1));

endmodule

// File: rtl/e1_align_sync.sv
module e1_align_sync #(
   parameter  int TS_COUNT      = 32,
   parameter  int TS_WIDTH      = 8,
   parameter  int LOSS_LIMIT    = 3,
   parameter  int MF_WINDOW     = 64,
   parameter  int CNT_W         = 12,
   parameter  int GIVEUP_FRAMES = 3200,
   localparam int TS_IDX_W      = $clog2(TS_COUNT),
   localparam int BIT_IDX_W     = $clog2(TS_WIDTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_bit,
   input  logic                 crc_en,
   input  logic                 resync,
   output logic                 frame_pulse,
   output logic                 mf_pulse,
   output logic [TS_IDX_W-1:0]  timeslot,
   output logic [BIT_IDX_W-1:0] bit_pos,
   output logic                 in_sync,
   output logic                 sync_lost,
   output logic                 crc_lock,
   output logic [CNT_W-1:0]     crc_search_cnt,
   output logic                 crc_giveup
);

   localparam int POS_W = TS_IDX_W + BIT_IDX_W;

   logic [POS_W-1:0] pos;
   logic             tick;
   logic             fas_frame;

   e1s_frame_align #(
      .TS_COUNT   (TS_COUNT),
      .TS_WIDTH   (TS_WIDTH),
      .LOSS_LIMIT (LOSS_LIMIT)
   ) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_bit      (rx_bit),
      .resync      (resync),
      .pos         (pos),
      .in_sync     (in_sync),
      .sync_lost   (sync_lost),
      .tick        (tick),
      .fas_frame   (fas_frame),
      .frame_pulse (frame_pulse)
   );

   e1s_mf_align #(
      .POS_W     (POS_W),
      .MF_WINDOW (MF_WINDOW)
   ) u_mf (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_bit      (rx_bit),
      .crc_en      (crc_en),
      .in_sync     (in_sync),
      .tick        (tick),
      .fas_frame   (fas_frame),
      .frame_pulse (frame_pulse),
      .pos         (pos),
      .mf_lock     (crc_lock),
      .mf_pulse    (mf_pulse)
   );

   e1s_search_timer #(
      .CNT_W         (CNT_W),
      .GIVEUP_FRAMES (GIVEUP_FRAMES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .crc_en  (crc_en),
      .in_sync (in_sync),
      .tick    (tick),
      .mf_lock (crc_lock),
      .count   (crc_search_cnt),
      .giveup  (crc_giveup)
   );

   assign timeslot = pos[POS_W-1:BIT_IDX_W];
   assign bit_pos  = pos[BIT_IDX_W-1:0];

endmodule

// File: tb/e1_align_sync_bench.sv
`timescale 1ns/100ps
module e1_align_sync_bench;

   localparam int GIVEUP = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_bit = 1'b1;
   logic        crc_en = 1'b0;
   logic        resync = 1'b0;
   logic        frame_pulse, mf_pulse, in_sync, sync_lost, crc_lock, crc_giveup;
   logic [4:0]  timeslot;
   logic [2:0]  bit_pos;
   logic [11:0] crc_search_cnt;

   int checks = 0;
   int fails  = 0;
   int fp_cnt, fp_at0, mp_cnt, mp_at0, pos_bad;

   always #2.5 clk = ~clk;

   e1_align_sync #(.GIVEUP_FRAMES(GIVEUP)) u_e1_align_sync (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .crc_en(crc_en), .resync(resync),
      .frame_pulse(frame_pulse), .mf_pulse(mf_pulse), .timeslot(timeslot),
      .bit_pos(bit_pos), .in_sync(in_sync), .sync_lost(sync_lost),
      .crc_lock(crc_lock), .crc_search_cnt(crc_search_cnt), .crc_giveup(crc_giveup)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   task automatic send_idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_bit = 1'b1;
      end
   endtask

   // One 256-bit frame; timeslot 0 chosen by kind, payload all ones
   task automatic send_frame(input bit is_fas, input bit good, input bit si, input bit do_resync);
      logic [7:0] ts0;
      if (is_fas) ts0 = good ? {si, 7'b0011011} : 8'hFF;
      else        ts0 = good ? {si, 7'b1011111} : {si, 7'b0011111};
      fp_cnt = 0; fp_at0 = 0; mp_cnt = 0; mp_at0 = 0; pos_bad = 0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         rx_bit = (i < 8) ? ts0[7 - i] : 1'b1;
         resync = do_resync && (i == 100);
         #1;
         if (frame_pulse) begin fp_cnt++; if (i == 0) fp_at0 = 1; end
         if (mf_pulse)    begin mp_cnt++; if (i == 0 && frame_pulse) mp_at0 = 1; end
         if (in_sync && (timeslot != 5'(i / 8) || bit_pos != 3'(i % 8))) pos_bad++;
      end
      resync = 1'b0;
   endtask

   function automatic bit mf_si(input int gf, input bit corrupt);
      int m = gf % 16;
      logic [5:0] w = 6'b001011;
      if (m % 2 == 1 && m <= 11) begin
         if (corrupt && m == 11) return 1'b0;
         return w[5 - (m - 1) / 2];
      end
      return 1'b1;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      send_idle(4);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk(!in_sync && !sync_lost && !crc_lock && !crc_giveup, "R1 flags after reset",
          {in_sync, sync_lost, crc_lock, crc_giveup}, 0);
      chk(crc_search_cnt == 0 && !frame_pulse && !mf_pulse, "R1 count and pulses",
          crc_search_cnt, 0);
   endtask

   task automatic t_acquire();
      send_idle(37);
      send_frame(1, 1, 1, 0);
      chk(!in_sync, "R2 no sync after first FAS", in_sync, 0);
      send_frame(0, 1, 1, 0);
      chk(!in_sync, "R2 no sync after NFAS", in_sync, 0);
      send_frame(1, 1, 1, 0);
      chk(in_sync, "R2 sync after second FAS", in_sync, 1);
      send_frame(0, 1, 1, 0);
      chk(fp_cnt == 1 && fp_at0 == 1, "R4 one frame pulse at bit 1", fp_cnt, 1);
      chk(pos_bad == 0, "R4 timeslot and bit position", pos_bad, 0);
      send_frame(1, 1, 1, 0);
      chk(fp_cnt == 1 && fp_at0 == 1, "R4 pulse in alignment frame", fp_cnt, 1);
   endtask

   task automatic t_resync();
      send_frame(0, 1, 1, 1);
      chk(!in_sync, "R6 resync drops alignment", in_sync, 1'b0);
   endtask

   task automatic t_false_nfas();
      send_frame(1, 1, 1, 0);
      send_frame(0, 0, 1, 0);
      send_frame(1, 1, 1, 0);
      chk(!in_sync, "R3 bad NFAS blocks sync", in_sync, 0);
      send_frame(0, 1, 1, 0);
      send_frame(1, 1, 1, 0);
      chk(in_sync, "R3 sync after fresh sequence", in_sync, 1);
   endtask

   task automatic t_loss();
      send_frame(0, 1, 1, 0); send_frame(1, 0, 1, 0);
      send_frame(0, 1, 1, 0); send_frame(1, 0, 1, 0);
      send_frame(0, 1, 1, 0); send_frame(1, 1, 1, 0);
      send_frame(0, 1, 1, 0); send_frame(1, 0, 1, 0);
      send_frame(0, 1, 1, 0); send_frame(1, 0, 1, 0);
      send_frame(0, 1, 1, 0);
      chk(in_sync && !sync_lost, "R5 two errors keep sync", in_sync, 1);
      send_frame(1, 0, 1, 0);
      chk(!in_sync, "R5 third error drops sync", in_sync, 0);
      chk(sync_lost, "R5 loss flag set", sync_lost, 1);
      send_frame(0, 1, 1, 0); send_frame(1, 1, 1, 0); send_frame(0, 1, 1, 0);
      chk(sync_lost && !in_sync, "R5 loss flag held while hunting", sync_lost, 1);
      send_frame(1, 1, 1, 0);
      chk(in_sync && !sync_lost, "R5 loss flag cleared on realign", sync_lost, 0);
   endtask

   task automatic t_crc_lock();
      crc_en = 1'b1;
      do_reset();
      for (int gf = 0; gf < 64; gf++) begin
         send_frame(gf % 2 == 0, 1, mf_si(gf, 0), 0);
         if (gf == 21) chk(!crc_giveup && crc_search_cnt == 19, "R12 below limit", crc_search_cnt, 19);
         if (gf == 22) chk(crc_giveup && crc_search_cnt == 20, "R12 at limit", crc_search_cnt, 20);
         if (gf == 42) begin
            chk(!crc_lock, "R7 no lock before second word", crc_lock, 0);
            chk(crc_search_cnt == 40, "R10 count before lock", crc_search_cnt, 40);
         end
         if (gf == 43) begin
            chk(crc_lock, "R7 lock on second word", crc_lock, 1);
            chk(crc_search_cnt == 0 && !crc_giveup, "R10 count cleared on lock", crc_search_cnt, 0);
         end
         if (gf >= 44 && gf <= 47) chk(mp_cnt == 0, "R8 no multiframe pulse", mp_cnt, 0);
         if (gf == 48) chk(mp_cnt == 1 && mp_at0 == 1, "R8 multiframe pulse at frame 0", mp_cnt, 1);
      end
      crc_en = 1'b0;
      send_frame(1, 1, mf_si(64, 0), 0);
      chk(!crc_lock && crc_search_cnt == 0, "R11 disabled clears lock and count", crc_search_cnt, 0);
      send_frame(0, 1, mf_si(65, 0), 0);
      chk(crc_search_cnt == 0, "R11 count held while disabled", crc_search_cnt, 0);
      crc_en = 1'b1;
      send_frame(1, 1, mf_si(66, 0), 0);
      send_frame(0, 1, mf_si(67, 0), 0);
      chk(crc_search_cnt == 2 && !crc_lock, "R10 count resumes after enable", crc_search_cnt, 2);
   endtask

   task automatic t_crc_window();
      crc_en = 1'b1;
      do_reset();
      for (int gf = 0; gf < 108; gf++) begin
         send_frame(gf % 2 == 0, 1, mf_si(gf, gf >= 32 && gf < 80), 0);
         if (gf == 91) chk(!crc_lock, "R9 expired window restarts", crc_lock, 0);
         if (gf == 106) chk(!crc_lock, "R9 no lock before restart pair", crc_lock, 0);
         if (gf == 107) chk(crc_lock, "R9 lock from restarted window", crc_lock, 1);
      end
   endtask

   initial begin
      t_reset();
      t_acquire();
      t_resync();
      t_false_nfas();
      t_loss();
      t_crc_lock();
      t_crc_window();
      summary();
      $finish;
   end

endmodule